// File: doc/BRIEF.md
# Seekable PCG Random Generator

This block returns the pseudo-random word at any chosen index of a 64-bit linear congruential sequence. It does not walk through the earlier indices. A request carries a 64-bit seed, a 64-bit stream selector and a position. The block jumps to the requested index by composing affine maps of the form `x -> m*x + a`. It scans the position one bit at a time, least significant bit first, and squares the current map after every bit. The number of cycles therefore grows with the bit length of the position, not with its value.

Once the target state is known, the block scrambles it with an output permutation. The permutation is an xorshift by a state-dependent amount, a multiply by a fixed odd constant, and a final xorshift. The result is presented on a 64-bit output register. All products go through one shared 64x64 low-half multiplier, which is used for several cycles per position bit.

A caller raises `start` while the block is idle. It then waits for the one-cycle `done` pulse. `busy` is high for the whole computation, and requests made while it is high are dropped.

Top module: `pcg_seek_gen`

## Requirements
- R1: The generator recurrence is `x' = x*6364136223846793005 + inc`, with all arithmetic taken modulo 2^64.
- R2: The increment is `2*stream + 1` modulo 2^64, so it is always odd. Two stream values that differ only in bit 63 therefore give identical results.
- R3: For position n, the result is the permutation applied to the state reached from the seed after exactly n applications of the recurrence.
- R4: The permutation takes state s and computes `w = s ^ (s >> (s[63:59] + 5))`, then `w = w * 12605985483714917081`, and returns `w ^ (w >> 43)`. Position 0 returns the permutation of the seed itself.
- R5: A `start` seen while `busy` is low is accepted, and `busy` is high in the next cycle. `done` is a single-cycle pulse. While `done` is high, `busy` is low and `result` holds the answer.
- R6: A `start` raised while `busy` is high is ignored. It neither produces a `done` pulse nor changes the pending result.
- R7: `result` changes only in a cycle in which `done` is high, and it holds its value until the next `done`.
- R8: `done` rises no later than 4*POS_W + 3 rising edges after the edge that accepts the request. This count includes the accepting edge.
- R9: After reset, `busy`, `done` and `result` are all zero.
- R10: Identical seed, stream and position always produce an identical result, including for the all-ones position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled only while idle |
| seed | input | 64 | Starting state of the sequence |
| stream | input | 64 | Stream selector; the increment is 2*stream+1 |
| position | input | POS_W | Index of the requested element |
| busy | output | 1 | High while a request is being computed |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 64 | Permuted output for the requested index |

## Verification
The main function is exercised in three ways, each against a model that steps the recurrence one index at a time:
- Positions 0 to 20 at several seeds and streams. Any error in the order in which maps are composed, or in the squaring of the current addend, shows up as a mismatch at specific bit patterns.
- Larger sparse and dense positions, such as powers of two, 255 and 1000. These separate the bit-set path from the squaring-only path.
- Position 0 on its own. It isolates the output permutation from the jump-ahead.

Stream pairs that differ only in the top bit check the wrap of the increment. Repeated all-ones requests check determinism and the worst-case latency. A burst of `start` pulses during a busy computation checks that extra requests are dropped.

// File: rtl/pcg_seek_pkg.sv
package pcg_seek_pkg;

    localparam int unsigned WORD_W     = 64;
    localparam int unsigned ROT_FIELD  = 5;
    localparam int unsigned ROT_BASE   = 5;
    localparam int unsigned FOLD_SHIFT = 43;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t LCG_MULT = 64'd6364136223846793005;
    localparam word_t MIX_MULT = 64'd12605985483714917081;

    // Affine map x -> mult*x + plus
    typedef struct packed {
        word_t mult;
        word_t plus;
    } affine_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC_M,
        ST_ACC_P,
        ST_CUR_P,
        ST_CUR_M,
        ST_FINAL,
        ST_MIX
    } seek_state_e;

    // First xorshift of the output permutation; shift picked by top bits
    function automatic word_t pre_mix(word_t s);
        logic [ROT_FIELD:0] amt;
        amt = {1'b0, s[WORD_W-1 -: ROT_FIELD]} + (ROT_FIELD+1)'(ROT_BASE);
        return s ^ (s >> amt);
    endfunction

    function automatic word_t post_mix(word_t w);
        return w ^ (w >> FOLD_SHIFT);
    endfunction

endpackage

// File: rtl/pcg_mul_lo.sv
module pcg_mul_lo #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prod
);
    // Low half of the product only: arithmetic modulo 2^W
    always_comb prod = op_a * op_b;
endmodule

// File: rtl/pcg_mix_stage.sv
module pcg_mix_stage
    import pcg_seek_pkg::*;
(
    input  word_t lcg_state,
    input  word_t mixed_prod,
    output word_t mix_in,
    output word_t mix_out
);
    always_comb begin
        mix_in  = pre_mix(lcg_state);
        mix_out = post_mix(mixed_prod);
    end
endmodule

// File: rtl/pcg_seek_gen.sv
module pcg_seek_gen
    import pcg_seek_pkg::*;
#(
    parameter int unsigned POS_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [63:0]      seed,
    input  logic [63:0]      stream,
    input  logic [POS_W-1:0] position,
    output logic             busy,
    output logic             done,
    output logic [63:0]      result
);

    seek_state_e      state_q;
    affine_t          acc_q;
    affine_t          cur_q;
    word_t            seed_q;
    word_t            lcg_q;
    logic [POS_W-1:0] pos_q;

    word_t mul_a, mul_b, prod;
    word_t mix_in, mix_out;

    // Choose the next step from the remaining position bits
    function automatic seek_state_e pick_next(logic [POS_W-1:0] p);
        if (p == '0)  return ST_FINAL;
        else if (p[0]) return ST_ACC_M;
        else           return ST_CUR_P;
    endfunction

    pcg_mul_lo #(.W(WORD_W)) u_mul (
        .op_a (mul_a),
        .op_b (mul_b),
        .prod (prod)
    );

    pcg_mix_stage u_mix (
        .lcg_state  (lcg_q),
        .mixed_prod (prod),
        .mix_in     (mix_in),
        .mix_out    (mix_out)
    );

    // Operand steering for the single shared multiplier
    always_comb begin
        mul_a = acc_q.mult;
        mul_b = cur_q.mult;
        unique case (state_q)
            ST_ACC_P: begin mul_a = acc_q.plus;         mul_b = cur_q.mult; end
            ST_CUR_P: begin mul_a = cur_q.mult + 64'd1; mul_b = cur_q.plus; end
            ST_CUR_M: begin mul_a = cur_q.mult;         mul_b = cur_q.mult; end
            ST_FINAL: begin mul_a = acc_q.mult;         mul_b = seed_q;     end
            ST_MIX:   begin mul_a = mix_in;             mul_b = MIX_MULT;   end
            default:  begin mul_a = acc_q.mult;         mul_b = cur_q.mult; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            cur_q   <= '0;
            seed_q  <= '0;
            lcg_q   <= '0;
            pos_q   <= '0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    seed_q     <= seed;
                    acc_q.mult <= 64'd1;
                    acc_q.plus <= '0;
                    cur_q.mult <= LCG_MULT;
                    cur_q.plus <= {stream[62:0], 1'b1};
                    pos_q      <= position;
                    state_q    <= pick_next(position);
                end
                ST_ACC_M: begin
                    acc_q.mult <= prod;
                    state_q    <= ST_ACC_P;
                end
                ST_ACC_P: begin
                    acc_q.plus <= prod + cur_q.plus;
                    state_q    <= ST_CUR_P;
                end
                ST_CUR_P: begin
                    cur_q.plus <= prod;
                    state_q    <= ST_CUR_M;
                end
                ST_CUR_M: begin
                    cur_q.mult <= prod;
                    pos_q      <= pos_q >> 1;
                    state_q    <= pick_next(pos_q >> 1);
                end
                ST_FINAL: begin
                    lcg_q   <= prod + acc_q.plus;
                    state_q <= ST_MIX;
                end
                ST_MIX: begin
                    result  <= mix_out;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pcg_seek_checker.sv
module pcg_seek_checker #(
    parameter int unsigned POS_W = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [63:0] result
);
    localparam int unsigned LAT_MAX = 4 * POS_W + 2;
    localparam int unsigned CNT_W   = $clog2(LAT_MAX + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    p_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_after_work_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    p_latency_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < CNT_W'(LAT_MAX)));

endmodule

bind pcg_seek_gen pcg_seek_checker #(.POS_W(POS_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/pcg_seek_gen_bench.sv
module pcg_seek_gen_bench;

    localparam int unsigned POS_W = 64;
    localparam logic [63:0] M_LCG = 64'd6364136223846793005;
    localparam logic [63:0] M_MIX = 64'd12605985483714917081;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [63:0]      seed = '0;
    logic [63:0]      stream = '0;
    logic [POS_W-1:0] position = '0;
    logic             busy, done;
    logic [63:0]      result;

    always #5 clk = ~clk;

    pcg_seek_gen #(.POS_W(POS_W)) u_pcg_seek_gen (
        .clk(clk), .rst(rst), .start(start), .seed(seed), .stream(stream),
        .position(position), .busy(busy), .done(done), .result(result)
    );

    typedef struct {
        logic [63:0] exp;
        bit          cmp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          t_issue = 0;
    int          done_cnt = 0;
    int          last_lat = 0;
    logic [63:0] last_result = '0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Independent model: permutation written from R4
    function automatic logic [63:0] ref_mix(logic [63:0] s);
        logic [63:0] w;
        int sh;
        sh = int'(s[63:59]) + 5;
        w  = (s >> sh) ^ s;
        w  = w * M_MIX;
        return w ^ (w >> 43);
    endfunction

    // Sequential stepping model (R1, R2, R3)
    function automatic logic [63:0] ref_out(logic [63:0] sd, logic [63:0] st, int unsigned n);
        logic [63:0] x;
        logic [63:0] inc;
        x   = sd;
        inc = st * 64'd2 + 64'd1;
        for (int unsigned i = 0; i < n; i++) x = x * M_LCG + inc;
        return ref_mix(x);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [63:0] sd, logic [63:0] st, logic [POS_W-1:0] p,
                         bit cmp, logic [63:0] exp, string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        seed = sd; stream = st; position = p; start = 1'b1;
        it.exp = exp; it.cmp = cmp; it.tag = tag;
        sb_q.push_back(it);
        t_issue = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic issue_ref(logic [63:0] sd, logic [63:0] st, int unsigned n, string tag);
        issue(sd, st, POS_W'(n), 1'b1, ref_out(sd, st, n), tag);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            item_t it;
            last_result = result;
            last_lat    = cyc - t_issue;
            done_cnt++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", result, '0);
            end else begin
                it = sb_q.pop_front();
                if (it.cmp) check(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] r_a, r_b, held;
        int          dc;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy === 1'b0, "R9 busy", 64'(busy), 0);
        check(done === 1'b0, "R9 done", 64'(done), 0);
        check(result === 64'd0, "R9 result", result, 0);
        rst = 1'b0;

        // R4: position 0 is the permuted seed
        issue(64'd42, 64'd0, '0, 1'b1, ref_mix(64'd42), "R4 pos0 seed42");
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd9, '0, 1'b1,
              ref_mix(64'hFFFF_FFFF_FFFF_FFFF), "R4 pos0 all-ones seed");
        drain();
        check(last_lat <= 4*POS_W+3, "R8 latency pos0", 64'(last_lat), 64'(4*POS_W+3));

        // R1, R3: small positions against stepping model
        for (int n = 0; n <= 20; n++) issue_ref(64'd77, 64'd2, n, "R3 small positions");
        for (int n = 1; n <= 8; n++)  issue_ref(64'hDEAD_BEEF, 64'd1, n, "R1 alt seed");
        issue_ref(64'd5, 64'd11, 128, "R3 power of two");
        issue_ref(64'd5, 64'd11, 255, "R3 dense bits");
        issue_ref(64'h0123_4567_89AB_CDEF, 64'd3, 1000, "R3 pos 1000");
        issue_ref(64'd99, 64'd7, 513, "R3 sparse bits");
        drain();

        // R2: top stream bit has no effect
        issue_ref(64'd42, 64'd5, 50, "R2 stream 5");
        issue_ref(64'd42, 64'h8000_0000_0000_0005, 50, "R2 stream 5 with msb");
        drain();

        // R6: starts during busy are dropped
        dc = done_cnt;
        issue_ref(64'd1234, 64'd4, 300, "R6 first request result");
        repeat (3) begin
            @(negedge clk);
            seed = 64'd1; stream = 64'd1; position = 64'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        drain();
        repeat (12) @(negedge clk);
        check(done_cnt == dc + 1, "R6 single done", 64'(done_cnt - dc), 1);

        // R7: result holds after done
        held = last_result;
        repeat (10) @(negedge clk);
        check(result === held, "R7 result hold", result, held);

        // R10, R8: all-ones position, repeated and stream-wrapped
        issue(64'd42, 64'd6, '1, 1'b0, '0, "R10 big a");
        drain();
        r_a = last_result;
        check(last_lat <= 4*POS_W+3, "R8 latency all-ones", 64'(last_lat), 64'(4*POS_W+3));
        issue(64'd42, 64'd6, '1, 1'b0, '0, "R10 big b");
        drain();
        r_b = last_result;
        check(r_a === r_b, "R10 determinism", r_b, r_a);
        issue(64'd42, 64'h8000_0000_0000_0006, '1, 1'b0, '0, "R2 big wrap");
        drain();
        check(last_result === r_a, "R2 big wrap", last_result, r_a);
        check(done_cnt == dc + 4, "R5 done count", 64'(done_cnt - dc), 4);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule